// File: doc/BRIEF.md
# Interrupt Status Aggregator with Clear-on-Read

This block collects fifteen interrupt condition inputs behind an APB slave port. Each condition is caught in a sticky status bit. A read/write enable mask selects which caught bits drive a single registered interrupt line. Both the status and the enable vectors are split into a low byte and a high byte on an 8-bit data path. This lets a 16-bit access reach each pair of bytes.

Software finds out which sources fired by reading the status bytes. A read clears only those bits in the addressed byte whose condition input has dropped. A bit whose condition is still asserted, or is asserted in the same cycle as the read, stays set. No event is lost between the read and the clear. Writes to the status bytes are ignored.

The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `irq_agg_apb`

## Requirements
- R1: After reset, the bytes at 0x16, 0x17, 0x18 and 0x19 all read 0x00, and `irq_out` is low.
- R2: If `src_cond[i]` is high at a rising clock edge, status bit i is set from that edge onward, whatever the enable mask holds. Status bits 7:0 read at 0x18 bits 7:0. Status bits 14:8 read at 0x19 bits 6:0.
- R3: An access-phase read (`psel`=1, `penable`=1, `pwrite`=0) of a status byte returns the bits held before the access. After the access, every bit of that byte whose condition input is low is cleared.
- R4: A status bit whose condition is high during the access phase of a read of its byte is still set after the read. This includes a condition that first rises in that same cycle.
- R5: A read of one status byte leaves the bits of the other status byte unchanged.
- R6: The enable mask is read/write. Bits 7:0 sit at 0x16 bits 7:0. Bits 14:8 sit at 0x19-1 = 0x17 bits 6:0. Bit 7 of 0x17 always reads 0, and writes to it are dropped.
- R7: `irq_out` is a register. It goes high one cycle after any status bit that is both set and enabled, and goes low one cycle after no such bit remains.
- R8: Writes to 0x18 and 0x19 have no effect. A read of any address other than 0x16 to 0x19 returns 0x00 and changes nothing.
- R9: A setup-phase cycle (`penable`=0) never clears status. `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and block clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 5 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, combinational from the addressed byte |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0 |
| src_cond | input | 15 | Per-source interrupt condition, level sampled each clock |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The assertions assume three things about the bus and the sources. The bus follows the APB ordering: a setup cycle comes before each access cycle, and `paddr`/`pwrite` stay steady across both. The condition inputs are synchronous to `pclk`. The byte-isolation and clear checks also assume that a read is the only path that clears a bit. The bench therefore drives every input on the falling edge. It builds each transfer as one setup cycle followed by one access cycle. It makes conditions rise and fall only between transfers, except in the one case that deliberately places a new condition inside the access cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NSRC   = 15;
  localparam int unsigned HI_W   = NSRC - DATA_W;
  localparam int unsigned PAD_W  = DATA_W - HI_W;

  localparam logic [ADDR_W-1:0] ADDR_EN_LO = 5'h16;
  localparam logic [ADDR_W-1:0] ADDR_EN_HI = 5'h17;
  localparam logic [ADDR_W-1:0] ADDR_ST_LO = 5'h18;
  localparam logic [ADDR_W-1:0] ADDR_ST_HI = 5'h19;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_apb_decode.sv
module irq_apb_decode
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  src_vec_t          status_i,
  input  src_vec_t          enable_i,
  output logic              en_wr_lo,
  output logic              en_wr_hi,
  output src_vec_t          clr_mask,
  output logic [DATA_W-1:0] prdata
);
  logic acc_rd, acc_wr;
  logic hit_en_lo, hit_en_hi, hit_st_lo, hit_st_hi;

  always_comb begin
    acc_rd    = psel && penable && !pwrite;
    acc_wr    = psel && penable && pwrite;
    hit_en_lo = (paddr == ADDR_EN_LO);
    hit_en_hi = (paddr == ADDR_EN_HI);
    hit_st_lo = (paddr == ADDR_ST_LO);
    hit_st_hi = (paddr == ADDR_ST_HI);
    en_wr_lo  = acc_wr && hit_en_lo;
    en_wr_hi  = acc_wr && hit_en_hi;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    if (i < DATA_W) begin : g_lo
      assign clr_mask[i] = acc_rd && hit_st_lo;
    end else begin : g_hi
      assign clr_mask[i] = acc_rd && hit_st_hi;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      unique case (1'b1)
        hit_en_lo: prdata = enable_i[DATA_W-1:0];
        hit_en_hi: prdata = {{PAD_W{1'b0}}, enable_i[NSRC-1:DATA_W]};
        hit_st_lo: prdata = status_i[DATA_W-1:0];
        hit_st_hi: prdata = {{PAD_W{1'b0}}, status_i[NSRC-1:DATA_W]};
        default:   prdata = '0;
      endcase
    end
  end

  // R9: a setup cycle never produces a clear
  a_r9_setup_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !penable |-> (clr_mask == '0));
  // R6: the padding bit of a high byte always reads zero
  a_r6_hi_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && (hit_en_hi || hit_st_hi)) |-> !prdata[DATA_W-1]);
  // R5: a clear never covers both bytes at once
  a_r5_one_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_mask[0] && clr_mask[NSRC-1]));
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output src_vec_t          en_q
);
  src_vec_t en_d;

  always_comb begin
    en_d = en_q;
    if (wr_lo) en_d[DATA_W-1:0]    = wdata;
    if (wr_hi) en_d[NSRC-1:DATA_W] = wdata[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_lo || wr_hi) en_q <= en_d;
  end

  // R6: a low-byte write lands in the mask one cycle later
  a_r6_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (en_q[DATA_W-1:0] == $past(wdata)));
  // R8: the mask changes only through an enable write
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi) |=> $stable(en_q));
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_agg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t cond_i,
  input  src_vec_t clr_mask,
  output src_vec_t status_q
);
  src_vec_t status_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_comb begin
      if (cond_i[i])        status_d[i] = 1'b1;
      else if (clr_mask[i]) status_d[i] = 1'b0;
      else                  status_d[i] = status_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  // R2: every sampled condition is held in status
  a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(cond_i)) == $past(cond_i)));
  // R3: cleared bits with no condition end up zero
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_mask) & ~$past(cond_i)) == '0));
  // R5: bits neither cleared nor set keep their value
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(clr_mask) & ~$past(cond_i)) ==
              ($past(status_q) & ~$past(clr_mask) & ~$past(cond_i))));
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import irq_agg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t status_i,
  input  src_vec_t enable_i,
  output logic     irq_q
);
  logic irq_d;

  always_comb irq_d = |(status_i & enable_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // R7: the line follows enabled status with one cycle of delay
  a_r7_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == |($past(status_i) & $past(enable_i))));
endmodule

// File: rtl/irq_agg_apb.sv
module irq_agg_apb
  import irq_agg_pkg::*;
(
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [NSRC-1:0]   src_cond,
  output logic              irq_out
);
  logic     rst_meta, rst_n;
  logic     en_wr_lo, en_wr_hi;
  src_vec_t clr_mask, status_q, en_q;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  irq_apb_decode u_dec (
    .clk(pclk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .status_i(status_q), .enable_i(en_q),
    .en_wr_lo(en_wr_lo), .en_wr_hi(en_wr_hi), .clr_mask(clr_mask),
    .prdata(prdata)
  );

  irq_enable_reg u_en (
    .clk(pclk), .rst_n(rst_n), .wr_lo(en_wr_lo), .wr_hi(en_wr_hi),
    .wdata(pwdata), .en_q(en_q)
  );

  irq_status_bank u_st (
    .clk(pclk), .rst_n(rst_n), .cond_i(src_cond), .clr_mask(clr_mask),
    .status_q(status_q)
  );

  irq_combine u_irq (
    .clk(pclk), .rst_n(rst_n), .status_i(status_q), .enable_i(en_q),
    .irq_q(irq_out)
  );

  // R4: a condition present during a status read survives the read
  a_r4_cond_wins: assert property (@(posedge pclk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_mask) & $past(src_cond)) ==
              ($past(clr_mask) & $past(src_cond))));
endmodule

// File: tb/tb_irq_agg_apb.sv
`timescale 1ns/1ps
module tb_irq_agg_apb;
  logic        pclk = 1'b0;
  logic        presetn, psel, penable, pwrite;
  logic [4:0]  paddr;
  logic [7:0]  pwdata, prdata;
  logic        pready, pslverr, irq_out;
  logic [14:0] src_cond;

  int checks = 0;
  int errors = 0;
  logic [14:0] exp_st = '0;
  logic [14:0] exp_en = '0;
  logic        exp_irq = 1'b0;
  logic [7:0]  sb_data[$];
  string       sb_tag[$];

  always #2.5 pclk = ~pclk;

  irq_agg_apb dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .src_cond(src_cond), .irq_out(irq_out)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // model the posedge between two falling edges
  task automatic tick(logic [14:0] clr);
    exp_irq = |(exp_st & exp_en);
    exp_st  = src_cond | (exp_st & ~clr);
    @(negedge pclk);
  endtask

  function automatic logic [7:0] exp_byte(logic [4:0] a);
    case (a)
      5'h16:   return exp_en[7:0];
      5'h17:   return {1'b0, exp_en[14:8]};
      5'h18:   return exp_st[7:0];
      5'h19:   return {1'b0, exp_st[14:8]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic apb_read(logic [4:0] a, string tag, logic [14:0] acc_cond = '0);
    logic [14:0] base, clr;
    base = src_cond;
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    tick('0);
    penable = 1'b1;
    src_cond = base | acc_cond;
    sb_data.push_back(exp_byte(a));
    sb_tag.push_back(tag);
    clr = (a == 5'h18) ? 15'h00FF : (a == 5'h19) ? 15'h7F00 : 15'h0000;
    tick(clr);
    psel = 1'b0; penable = 1'b0;
    src_cond = base;
  endtask

  task automatic apb_write(logic [4:0] a, logic [7:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    tick('0);
    penable = 1'b1;
    tick('0);
    if (a == 5'h16) exp_en[7:0]  = d;
    if (a == 5'h17) exp_en[14:8] = d[6:0];
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick('0);
  endtask

  task automatic pulse(logic [14:0] m);
    src_cond = m;
    tick('0);
    src_cond = '0;
  endtask

  task automatic check_irq(string tag);
    check(tag, {7'd0, irq_out}, {7'd0, exp_irq});
  endtask

  // scoreboard monitor: compare read data during each access phase
  initial begin
    forever begin
      @(negedge pclk);
      #1;
      if (psel && penable && !pwrite) begin
        if (sb_data.size() == 0) begin
          check("monitor: unexpected read", prdata, 8'hxx);
        end else begin
          logic [7:0] e;
          string t;
          e = sb_data.pop_front();
          t = sb_tag.pop_front();
          check(t, prdata, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; src_cond = '0;
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    idle(4);

    // R1 reset state
    check_irq("R1 irq after reset");
    apb_read(5'h16, "R1 enable lo reset");
    apb_read(5'h17, "R1 enable hi reset");
    apb_read(5'h18, "R1 status lo reset");
    apb_read(5'h19, "R1 status hi reset");
    // R9 tied responses
    check("R9 pready", {7'd0, pready}, 8'h01);
    check("R9 pslverr", {7'd0, pslverr}, 8'h00);

    // R6 enable readback
    apb_write(5'h16, 8'hA5);
    apb_write(5'h17, 8'hFF);
    apb_read(5'h16, "R6 enable lo readback");
    apb_read(5'h17, "R6 enable hi pad bit zero");

    // R2 latch of masked sources, R7 no irq
    pulse(15'h0042);
    idle(2);
    check_irq("R7 irq stays low for masked bits");
    apb_read(5'h18, "R2 status lo latched");
    apb_read(5'h18, "R3 status lo cleared");

    // R5 byte isolation, R7 irq rise and fall
    pulse(15'h4100);
    idle(2);
    check_irq("R7 irq high for enabled bits");
    apb_read(5'h18, "R5 lo read sees nothing");
    apb_read(5'h19, "R5 hi bits survive lo read");
    idle(1);
    check_irq("R7 irq low after clear");
    apb_read(5'h19, "R3 status hi cleared");

    // R4 held condition survives the read
    src_cond = 15'h0004;
    idle(2);
    apb_read(5'h18, "R4 held bit first read");
    apb_read(5'h18, "R4 held bit still set");
    src_cond = '0;
    idle(1);
    apb_read(5'h18, "R4 bit after drop");
    apb_read(5'h18, "R3 bit cleared after drop");

    // R4 condition arriving in the access cycle
    apb_read(5'h18, "R4 same cycle read data", 15'h0008);
    apb_read(5'h18, "R4 same cycle bit kept");
    apb_read(5'h18, "R3 same cycle bit later cleared");

    // R8 status writes ignored, unmapped reads zero
    pulse(15'h0010);
    apb_write(5'h18, 8'h00);
    apb_write(5'h19, 8'hFF);
    apb_read(5'h18, "R8 status lo unchanged by write");
    apb_read(5'h19, "R8 status hi unchanged by write");
    apb_read(5'h10, "R8 unmapped read zero");

    // R9 setup-only cycle does not clear
    pulse(15'h0020);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = 5'h18;
    tick('0);
    psel = 1'b0;
    idle(1);
    apb_read(5'h18, "R9 setup cycle left status");

    // R6 pad bit write dropped
    apb_write(5'h17, 8'h80);
    apb_read(5'h17, "R6 pad bit write dropped");
    idle(2);
    check_irq("R7 final irq state");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule